// File: doc/BRIEF.md
# Block Floating-Point Pass Normalizer

This block sits between two passes of an iterative fixed-point FFT datapath. Each pass reaches it as one frame of signed samples in the widened growth format. All samples of a frame share one exponent. While the frame streams in, the block stores it and measures how much headroom the largest sample leaves. It then plays the frame back with every sample scaled by the same power of two, so that the output words use the full narrower datapath width.

The chosen scale is reported as a signed per-pass exponent. A positive value means a left shift. A negative value means a right shift that discards growth bits, with rounding. A running block exponent adds up the per-pass exponents of one transform. A start pulse clears this sum at the beginning of a transform.

While a frame is being played back, input is held off. The next frame can enter in the cycle after the last output word.

Top module: `bfp_pass_norm`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `pass_exp` is 0 and `block_exp` is 0.
- R2: A sample is taken when `in_valid` and `in_ready` are both 1.
  - A frame ends on an accepted sample with `in_last` = 1, or on the DEPTH-th accepted sample, whichever comes first.
  - From the cycle after the frame ends until the last output word has been presented, `in_ready` is 0, and samples offered in that time are not taken.
  - `in_ready` returns to 1 in the cycle after the last output word.
- R3: Let w be the smallest two's-complement width that holds every sample of the frame. The per-pass exponent is WOUT - w, a signed value where positive means a left shift.
- R4: A frame whose samples are all zero gets exponent 0, and all of its output words are 0. A frame of all -1 is not treated as zero.
- R5: Playback timing and values:
  - Playback starts in the cycle right after the frame ends and runs one word per cycle with `out_valid` held at 1.
  - Words come out in arrival order, and `out_last` is 1 only on the final word.
  - Each word equals the sample times 2^exponent, in WOUT-bit two's complement.
- R6: On a right shift, the result is rounded to the nearest integer, with ties going away from zero (for example 0.5 → 1 and -0.5 → -1). A positive result that would round past 2^(WOUT-1)-1 is clamped to 2^(WOUT-1)-1.
- R7: `pass_exp` takes the new frame's exponent at the clock edge that ends the frame. It then holds that value through playback and until the next frame ends.
- R8: At the clock edge that ends a frame, `block_exp` adds that frame's exponent to its value.
  - A `tx_start` pulse sets `block_exp` to 0.
  - If `tx_start` coincides with the end of a frame, `block_exp` becomes that frame's exponent.
  - `block_exp` is wide enough to sum log2(DEPTH) passes of the largest exponent of either sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Clears the block exponent at the start of a transform |
| in_valid | input | 1 | Input sample valid |
| in_data | input | WIN | Signed input sample in growth format |
| in_last | input | 1 | Marks the final sample of a frame |
| in_ready | output | 1 | Block can accept a sample |
| out_valid | output | 1 | Output word valid |
| out_data | output | WOUT | Signed normalized sample |
| out_last | output | 1 | Marks the final word of a frame |
| pass_exp | output | EXP_W | Signed shift applied to the current frame |
| block_exp | output | BLK_W | Signed sum of pass exponents since the last start |

## Verification
The main function is driven with frames whose largest sample fits in less than the output width, which forces a left shift. It is also driven with full-width frames, which force a right shift with rounding ties and clamping at the positive limit.

All-zero frames and all-minus-one frames are both applied. These two cases share the same leading-bit count but must come out differently, which shows the zero case is handled on its own.

A frame that ends on the buffer depth without a last flag checks the implicit end of a frame. Samples offered during playback show that backpressure leaves the next frame's exponent unchanged.

The block exponent is followed across all frames, through a clear, and through a clear that lands on the same cycle as a frame end.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } bfp_state_e;
endpackage

// File: rtl/bfp_rst_sync.sv
module bfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/bfp_headroom.sv
module bfp_headroom #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  x,
  output logic [CW-1:0] run
);
  // chain[i] is 1 while bits W-1..i all equal the sign bit
  logic [W-1:0] chain;

  genvar gi;
  generate
    for (gi = W - 1; gi >= 0; gi--) begin : g_chain
      if (gi == W - 1) begin : g_top
        assign chain[gi] = 1'b1;
      end else begin : g_rest
        assign chain[gi] = chain[gi+1] & (x[gi] == x[W-1]);
      end
    end
  endgenerate

  always_comb begin
    run = '0;
    for (int i = 0; i < W; i++) begin
      run = run + CW'(chain[i]);
    end
  end
endmodule

// File: rtl/bfp_frame_buf.sv
module bfp_frame_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R2: no sample is stored while the frame is being played back
  a_r2_no_write_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !wr_en);
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler #(
  parameter int WIN   = 16,
  parameter int WOUT  = 12,
  parameter int EXP_W = 5
) (
  input  logic signed [WIN-1:0]   x,
  input  logic signed [EXP_W-1:0] shamt,
  output logic signed [WOUT-1:0]  y
);
  localparam logic signed [WOUT-1:0] MAXP = {1'b0, {(WOUT-1){1'b1}}};
  localparam logic [WIN-1:0]         ONE  = {{(WIN-1){1'b0}}, 1'b1};

  logic [EXP_W-1:0]      amt_l;
  logic [EXP_W-1:0]      amt_r;
  logic signed [WIN-1:0] lsh;
  logic signed [WIN-1:0] rsh;
  logic [WIN-1:0]        mask;
  logic [WIN-1:0]        half;
  logic [WIN-1:0]        frac;
  logic                  up;
  logic                  neg;

  always_comb begin
    amt_l = shamt;
    amt_r = -shamt;
    neg   = x[WIN-1];
    lsh   = x <<< amt_l;
    rsh   = x >>> amt_r;
    mask  = (ONE << amt_r) - ONE;
    half  = ONE << (amt_r - 1'b1);
    frac  = x & mask;
    // ties away from zero: positive rounds up at half, negative only above half
    up    = neg ? (frac > half) : (frac >= half);
    if (!shamt[EXP_W-1]) begin
      y = lsh[WOUT-1:0];
    end else if (up && !neg && (rsh[WOUT-1:0] == MAXP)) begin
      y = MAXP;
    end else begin
      y = rsh[WOUT-1:0] + WOUT'(up);
    end
  end
endmodule

// File: rtl/bfp_pass_norm.sv
module bfp_pass_norm #(
  parameter int WIN   = 16,
  parameter int WOUT  = 12,
  parameter int DEPTH = 8,
  parameter int EXP_W = $clog2((((WIN - WOUT) > (WOUT - 1)) ? (WIN - WOUT) : (WOUT - 1)) + 1) + 1,
  parameter int BLK_W = EXP_W + $clog2($clog2(DEPTH) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             in_valid,
  input  logic [WIN-1:0]   in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WOUT-1:0]  out_data,
  output logic             out_last,
  output logic [EXP_W-1:0] pass_exp,
  output logic [BLK_W-1:0] block_exp
);
  import bfp_pkg::*;

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(WIN + 1);
  localparam int GROW = WIN - WOUT;
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] RUN_INIT  = CW'(WIN);

  logic rst_ns;

  bfp_state_e      state_q, state_d;
  logic [AW-1:0]   wr_cnt_q, wr_cnt_d;
  logic [AW-1:0]   rd_cnt_q, rd_cnt_d;
  logic [AW-1:0]   len_m1_q, len_m1_d;
  logic [CW-1:0]   run_min_q, run_min_d;
  logic            any_nz_q, any_nz_d;
  logic [EXP_W-1:0] pass_exp_q, pass_exp_d;
  logic [BLK_W-1:0] block_exp_q, block_exp_d;

  logic            accept;
  logic            frame_end;
  logic [CW-1:0]   cur_run;
  logic [CW-1:0]   frame_min;
  logic            frame_nz;
  logic [EXP_W-1:0] shift_calc;
  logic [WIN-1:0]  rd_sample;
  logic            drain_step;

  bfp_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_ns)
  );

  bfp_headroom #(.W(WIN), .CW(CW)) u_head (
    .x  (in_data),
    .run(cur_run)
  );

  bfp_frame_buf #(.W(WIN), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (accept),
    .wr_addr(wr_cnt_q),
    .wr_data(in_data),
    .rd_en  (drain_step),
    .rd_addr(rd_cnt_q),
    .rd_data(rd_sample)
  );

  bfp_scaler #(.WIN(WIN), .WOUT(WOUT), .EXP_W(EXP_W)) u_scale (
    .x    (rd_sample),
    .shamt(pass_exp_q),
    .y    (out_data)
  );

  assign in_ready   = (state_q == ST_FILL);
  assign drain_step = (state_q == ST_DRAIN);
  assign accept     = in_valid && in_ready;
  assign frame_end  = accept && (in_last || (wr_cnt_q == LAST_ADDR));
  assign frame_min  = (cur_run < run_min_q) ? cur_run : run_min_q;
  assign frame_nz   = any_nz_q || (in_data != '0);

  always_comb begin
    int raw;
    raw = int'(frame_min) - 1 - GROW;
    shift_calc = frame_nz ? EXP_W'(raw) : '0;
  end

  // next-state logic
  always_comb begin
    state_d     = state_q;
    wr_cnt_d    = wr_cnt_q;
    rd_cnt_d    = rd_cnt_q;
    len_m1_d    = len_m1_q;
    run_min_d   = run_min_q;
    any_nz_d    = any_nz_q;
    pass_exp_d  = pass_exp_q;
    block_exp_d = tx_start ? '0 : block_exp_q;

    if (state_q == ST_FILL) begin
      if (frame_end) begin
        state_d     = ST_DRAIN;
        len_m1_d    = wr_cnt_q;
        wr_cnt_d    = '0;
        rd_cnt_d    = '0;
        run_min_d   = RUN_INIT;
        any_nz_d    = 1'b0;
        pass_exp_d  = shift_calc;
        block_exp_d = block_exp_d + {{(BLK_W-EXP_W){shift_calc[EXP_W-1]}}, shift_calc};
      end else if (accept) begin
        wr_cnt_d  = wr_cnt_q + 1'b1;
        run_min_d = frame_min;
        any_nz_d  = frame_nz;
      end
    end else begin
      if (rd_cnt_q == len_m1_q) begin
        state_d  = ST_FILL;
        rd_cnt_d = '0;
      end else begin
        rd_cnt_d = rd_cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q     <= ST_FILL;
      wr_cnt_q    <= '0;
      rd_cnt_q    <= '0;
      len_m1_q    <= '0;
      run_min_q   <= RUN_INIT;
      any_nz_q    <= 1'b0;
      pass_exp_q  <= '0;
      block_exp_q <= '0;
    end else begin
      state_q     <= state_d;
      wr_cnt_q    <= wr_cnt_d;
      rd_cnt_q    <= rd_cnt_d;
      len_m1_q    <= len_m1_d;
      run_min_q   <= run_min_d;
      any_nz_q    <= any_nz_d;
      pass_exp_q  <= pass_exp_d;
      block_exp_q <= block_exp_d;
    end
  end

  assign out_valid = drain_step;
  assign out_last  = drain_step && (rd_cnt_q == len_m1_q);
  assign pass_exp  = pass_exp_q;
  assign block_exp = block_exp_q;

  // R7: exponent does not move while a frame is played back
  a_r7_exp_stable: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_last) |=> $stable(pass_exp));

  // R8: the sum only moves on a frame end or a start pulse
  a_r8_blk_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!frame_end && !tx_start) |=> $stable(block_exp));

  // R5: the final word closes the playback
  a_r5_last_closes: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && out_last) |=> (!out_valid && in_ready));

  // R2: input is held off only while words are being played back
  a_r2_hold_while_drain: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_ready |-> out_valid);

  // R5: playback starts right after a frame end
  a_r5_start_after_end: assert property (@(posedge clk) disable iff (!rst_ns)
    frame_end |=> out_valid);
endmodule

// File: tb/bfp_pass_norm_test.sv
module bfp_pass_norm_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 16;
  localparam int WOUT  = 12;
  localparam int DEPTH = 8;
  localparam int EXP_W = 5;
  localparam int BLK_W = 7;
  localparam int NV    = 6;

  localparam logic [15:0] VEC_SAMP [NV][8] = '{
    '{16'h0100, 16'hFFFD, 16'h0064, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h7FFF, 16'h8000, 16'h0008, 16'h0018, 16'hFFF8, 16'hFFE8, 16'hFFF9, 16'h0028},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'hF000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0001, 16'h0002, 16'h0003, 16'hFFFB, 16'h0000, 16'h0006, 16'hFFFF, 16'h0005}
  };
  localparam int VEC_LEN  [NV] = '{4, 8, 3, 2, 1, 8};
  localparam bit VEC_LAST [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int VEC_EXP  [NV] = '{2, -4, 0, 11, -1, 8};

  logic clk = 1'b0;
  logic rst_n;
  logic tx_start;
  logic in_valid;
  logic [WIN-1:0] in_data;
  logic in_last;
  logic in_ready;
  logic out_valid;
  logic [WOUT-1:0] out_data;
  logic out_last;
  logic [EXP_W-1:0] pass_exp;
  logic [BLK_W-1:0] block_exp;

  int checks = 0;
  int failures = 0;
  int blk_model = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfp_pass_norm #(.WIN(WIN), .WOUT(WOUT), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .pass_exp(pass_exp), .block_exp(block_exp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int sx(input int v, input int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  // rounded scaled value per R5/R6, magnitude based
  function automatic int model_out(input int x, input int e);
    int a, ra, y;
    if (e >= 0) begin
      y = x * (1 << e);
    end else begin
      a  = (x < 0) ? -x : x;
      ra = (a + (1 << (-e - 1))) >> (-e);
      y  = (x < 0) ? -ra : ra;
      if (y > 2047) y = 2047;
    end
    return y;
  endfunction

  task automatic run_frame(input int v, input bit start_on_last);
    int e;
    e = VEC_EXP[v];
    for (int i = 0; i < VEC_LEN[v]; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready while filling", int'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = VEC_SAMP[v][i];
      in_last  = VEC_LAST[v] && (i == VEC_LEN[v] - 1);
      tx_start = start_on_last && (i == VEC_LEN[v] - 1);
    end
    @(posedge clk);
    @(negedge clk);
    tx_start = 1'b0;
    // junk offered during playback must be ignored (R2)
    in_valid = 1'b1;
    in_data  = 16'h7FFF;
    in_last  = 1'b1;
    if (start_on_last) blk_model = e; else blk_model = blk_model + e;
    chk(sx(int'(pass_exp), EXP_W) == e, "R3 R4 pass exponent", sx(int'(pass_exp), EXP_W), e);
    chk(sx(int'(block_exp), BLK_W) == blk_model, "R8 block exponent", sx(int'(block_exp), BLK_W), blk_model);
    for (int i = 0; i < VEC_LEN[v]; i++) begin
      chk(out_valid == 1'b1, "R5 valid contiguous", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R2 held off in playback", int'(in_ready), 0);
      chk(sx(int'(out_data), WOUT) == model_out(sx16(VEC_SAMP[v][i]), e),
          "R5 R6 output word", sx(int'(out_data), WOUT), model_out(sx16(VEC_SAMP[v][i]), e));
      chk(out_last == (i == VEC_LEN[v] - 1), "R5 last flag", int'(out_last), int'(i == VEC_LEN[v] - 1));
      chk(sx(int'(pass_exp), EXP_W) == e, "R7 exponent held", sx(int'(pass_exp), EXP_W), e);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(out_valid == 1'b0, "R5 playback ended", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R2 ready after playback", int'(in_ready), 1);
    chk(sx(int'(pass_exp), EXP_W) == e, "R7 exponent held after", sx(int'(pass_exp), EXP_W), e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_start = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(pass_exp == '0, "R1 pass_exp", int'(pass_exp), 0);
    chk(block_exp == '0, "R1 block_exp", int'(block_exp), 0);

    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    blk_model = 0;

    for (int v = 0; v < NV; v++) begin
      run_frame(v, 1'b0);
    end

    // R8: start pulse clears the sum
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    blk_model = 0;
    chk(block_exp == '0, "R8 start clears", sx(int'(block_exp), BLK_W), 0);

    // R8: start on the frame-ending cycle keeps that frame's exponent
    blk_model = 5;
    run_frame(4, 1'b1);

    // R4 contrast: all-zero after a nonzero frame restores exponent 0
    run_frame(2, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule